// File: doc/BRIEF.md
# DMA Socket State Controller

This block is the control engine for one DMA socket, the endpoint of a single independent data stream inside a DMA adapter. It tracks where the socket is in its lifecycle. It fetches a buffer descriptor through a request/acknowledge memory port and then waits for the fetch queue to report data. After that it lets the core move data beats. When the core signals end of packet, or the buffer fills, it runs a two-step size check. It then either resumes transfers or closes out the buffer.

Closing a buffer writes a short descriptor update back to memory (the number of bytes held in the buffer). If events are enabled, the block then raises an event request and holds it until the event is confirmed. A completed-transfer counter runs in bytes or in whole buffers, as a unit select input chooses. Once the counter reaches the requested transfer size, no further descriptor is fetched. The current lifecycle state is visible on a 3-bit status output.

Top module: `dma_sock_ctrl`

## Requirements
- R1: After reset, state_o is 0 (descriptor state), xfer_count_o is 0 and neither mem_req_o nor evt_req_o is asserted.
- R2: state_o encodes the lifecycle as 0 descriptor, 1 stall, 2 active, 3 event/write-back, 4 first check, 5 suspended, 6 second check, 7 waiting for event confirmation.
- R3: In state 0, a descriptor read is requested (mem_req_o=1, mem_we_o=0, mem_addr_o=dscr_ptr_i) only while en_i=1, susp_i=0 and the transfer is not complete. mem_ack_i on that request latches mem_rdata_i as the buffer size, and the socket moves to state 1 on the next cycle.
- R4: susp_i=1 in state 0 moves the socket to state 5, and it returns to 0 one cycle after susp_i drops. In every other state susp_i has no effect.
- R5: State 1 holds until data_rdy_i=1, then moves to 2. core_ready_o is 1 only in state 2.
- R6: In state 2, each cycle with core_valid_i adds core_bytes_i to the buffer fill. core_eop_i, or a fill that reaches the buffer size, moves the socket to 4, then always to 6.
- R7: From state 6 the socket goes to 3 if the buffer holds any bytes or the transfer size is reached; otherwise (an empty packet with size not reached) it returns to 2.
- R8: In state 3 a write-back is requested (mem_req_o=1, mem_we_o=1, mem_addr_o=dscr_ptr_i, mem_wdata_o=buffer fill). On mem_ack_i the next state is 7 if evt_en_i=1, else 0.
- R9: In state 7 evt_req_o is 1, and the socket stays there until evt_ack_i=1, after which it goes to 0.
- R10: With unit_buf_i=0, xfer_count_o grows by core_bytes_i on each accepted beat. With unit_buf_i=1, it grows by one on each acknowledged write-back and is unaffected by beats.
- R11: The transfer is complete when xfer_size_i is nonzero and xfer_count_o >= xfer_size_i, which blocks the descriptor read. xfer_size_i=0 means unlimited. In buffer unit, the size check in state 4 counts the buffer being closed.
- R12: en_i=0 sends the socket to state 0 and clears xfer_count_o on the next edge, from any state. A new descriptor does not clear the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Socket enable |
| susp_i | input | 1 | Suspend request |
| evt_en_i | input | 1 | Event generation enable |
| unit_buf_i | input | 1 | Count unit: 0 bytes, 1 buffers |
| xfer_size_i | input | CW | Requested transfer size (0 = unlimited) |
| dscr_ptr_i | input | AW | Descriptor address |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 write-back, 0 descriptor read |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | BW | Write-back data: bytes in buffer |
| mem_rdata_i | input | BW | Read data: buffer size in bytes |
| mem_ack_i | input | 1 | Memory acknowledge |
| data_rdy_i | input | 1 | Fetch queue holds data |
| core_valid_i | input | 1 | Core data beat |
| core_bytes_i | input | NW | Bytes in the beat |
| core_eop_i | input | 1 | End of packet |
| core_ready_o | output | 1 | Core may transfer |
| evt_req_o | output | 1 | Event pending confirmation |
| evt_ack_i | input | 1 | Event confirmed |
| state_o | output | 3 | Lifecycle state code |
| xfer_count_o | output | CW | Completed transfer count |

## Verification
The bench goes after the check decision. A zero-length end of packet must fall back to active, while the same packet at the size limit in buffer unit must close out. A design that skipped the buffer being closed would stall in active forever. It checks that suspend during a write-back or stall is ignored, since a design that honoured it would lose a buffer. It also checks that the count survives a new descriptor yet clears on disable, and that the event-disabled path skips the waiting state. A sweep over beat sizes with cumulative byte counts catches off-by-one fill detection, which would otherwise close a buffer one beat early or late.

// File: rtl/sock_pkg.sv
package sock_pkg;
  typedef enum logic [2:0] {
    ST_DESCR  = 3'd0,
    ST_STALL  = 3'd1,
    ST_ACTIVE = 3'd2,
    ST_EVENT  = 3'd3,
    ST_CHK1   = 3'd4,
    ST_SUSP   = 3'd5,
    ST_CHK2   = 3'd6,
    ST_WAIT   = 3'd7
  } sock_state_e;
endpackage

// File: rtl/sock_fsm.sv
module sock_fsm
  import sock_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        susp_i,
  input  logic        done_i,
  input  logic        mem_ack_i,
  input  logic        data_rdy_i,
  input  logic        eop_i,
  input  logic        full_i,
  input  logic        close_i,
  input  logic        evt_en_i,
  input  logic        evt_ack_i,
  output sock_state_e state_o,
  output logic        rd_req_o,
  output logic        wr_req_o
);
  sock_state_e state_q, state_d;

  assign rd_req_o = (state_q == ST_DESCR) && en_i && !susp_i && !done_i;
  assign wr_req_o = (state_q == ST_EVENT) && en_i;

  always_comb begin
    state_d = state_q;
    if (!en_i) begin
      state_d = ST_DESCR;
    end else begin
      unique case (state_q)
        ST_DESCR:  if (susp_i) state_d = ST_SUSP;
                   else if (rd_req_o && mem_ack_i) state_d = ST_STALL;
        ST_SUSP:   if (!susp_i) state_d = ST_DESCR;
        ST_STALL:  if (data_rdy_i) state_d = ST_ACTIVE;
        ST_ACTIVE: if (eop_i || full_i) state_d = ST_CHK1;
        ST_CHK1:   state_d = ST_CHK2;
        ST_CHK2:   state_d = close_i ? ST_EVENT : ST_ACTIVE;
        ST_EVENT:  if (mem_ack_i) state_d = evt_en_i ? ST_WAIT : ST_DESCR;
        ST_WAIT:   if (evt_ack_i) state_d = ST_DESCR;
        default:   state_d = ST_DESCR;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_DESCR;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  p_en_low_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> state_q == ST_DESCR);
  p_susp_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SUSP && $past(state_q) != ST_SUSP) |-> $past(state_q) == ST_DESCR);
  p_check_seq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_CHK2 |-> $past(state_q) == ST_CHK1);
  p_wait_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !evt_ack_i && en_i) |=> state_q == ST_WAIT);
endmodule

// File: rtl/sock_buf_track.sv
module sock_buf_track
  import sock_pkg::*;
#(
  parameter int unsigned BW = 16,
  parameter int unsigned NW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  sock_state_e   state_i,
  input  logic          load_i,
  input  logic [BW-1:0] size_i,
  input  logic          beat_i,
  input  logic [NW-1:0] bytes_i,
  output logic          full_o,
  output logic          nonempty_o,
  output logic [BW-1:0] fill_o
);
  localparam int unsigned FW = BW + 1;

  logic [BW-1:0] dscr_q;
  logic [FW-1:0] fill_q;
  logic [FW-1:0] fill_next;

  assign fill_next = fill_q + (beat_i ? FW'(bytes_i) : FW'(0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dscr_q <= '0;
      fill_q <= '0;
    end else if (!en_i) begin
      fill_q <= '0;
    end else if (load_i) begin
      dscr_q <= size_i;
      fill_q <= '0;
    end else if (beat_i) begin
      fill_q <= fill_next;
    end
  end

  assign full_o     = (state_i == ST_ACTIVE) && (fill_next >= FW'(dscr_q));
  assign nonempty_o = (fill_q != '0);
  assign fill_o     = fill_q[BW-1:0];

  p_fill_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ACTIVE && dscr_q != '0) |-> fill_q < FW'(dscr_q));
endmodule

// File: rtl/sock_xfer_cnt.sv
module sock_xfer_cnt
  import sock_pkg::*;
#(
  parameter int unsigned CW = 20,
  parameter int unsigned NW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  sock_state_e   state_i,
  input  logic          unit_buf_i,
  input  logic [CW-1:0] size_i,
  input  logic          beat_i,
  input  logic [NW-1:0] bytes_i,
  input  logic          wb_done_i,
  output logic          done_o,
  output logic          reach_o,
  output logic [CW-1:0] count_o
);
  logic [CW-1:0] count_q;
  logic          reach_q;
  logic [CW:0]   count_eff;

  assign count_eff = {1'b0, count_q} + (CW+1)'(unit_buf_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (!en_i) begin
      count_q <= '0;
    end else if (!unit_buf_i && beat_i) begin
      count_q <= count_q + CW'(bytes_i);
    end else if (unit_buf_i && wb_done_i) begin
      count_q <= count_q + 1'b1;
    end
  end

  // size check latched in the first check state, consumed in the second
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 reach_q <= 1'b0;
    else if (state_i == ST_CHK1) reach_q <= (size_i != '0) && (count_eff >= {1'b0, size_i});
  end

  assign done_o  = (size_i != '0) && (count_q >= size_i);
  assign reach_o = reach_q;
  assign count_o = count_q;

  p_cnt_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && count_q != $past(count_q)) |-> ($past(beat_i) || $past(wb_done_i)));
  p_cnt_clr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> count_q == '0);
endmodule

// File: rtl/dma_sock_ctrl.sv
module dma_sock_ctrl
  import sock_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned BW = 16,
  parameter int unsigned CW = 20,
  parameter int unsigned NW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          susp_i,
  input  logic          evt_en_i,
  input  logic          unit_buf_i,
  input  logic [CW-1:0] xfer_size_i,
  input  logic [AW-1:0] dscr_ptr_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [BW-1:0] mem_wdata_o,
  input  logic [BW-1:0] mem_rdata_i,
  input  logic          mem_ack_i,
  input  logic          data_rdy_i,
  input  logic          core_valid_i,
  input  logic [NW-1:0] core_bytes_i,
  input  logic          core_eop_i,
  output logic          core_ready_o,
  output logic          evt_req_o,
  input  logic          evt_ack_i,
  output logic [2:0]    state_o,
  output logic [CW-1:0] xfer_count_o
);
  sock_state_e   state;
  logic          rd_req, wr_req, done, reach, full, nonempty, beat;
  logic [BW-1:0] fill;

  assign beat = (state == ST_ACTIVE) && en_i && core_valid_i;

  sock_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .susp_i     (susp_i),
    .done_i     (done),
    .mem_ack_i  (mem_ack_i),
    .data_rdy_i (data_rdy_i),
    .eop_i      (core_eop_i),
    .full_i     (full),
    .close_i    (reach || nonempty),
    .evt_en_i   (evt_en_i),
    .evt_ack_i  (evt_ack_i),
    .state_o    (state),
    .rd_req_o   (rd_req),
    .wr_req_o   (wr_req)
  );

  sock_buf_track #(.BW(BW), .NW(NW)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .state_i    (state),
    .load_i     (rd_req && mem_ack_i),
    .size_i     (mem_rdata_i),
    .beat_i     (beat),
    .bytes_i    (core_bytes_i),
    .full_o     (full),
    .nonempty_o (nonempty),
    .fill_o     (fill)
  );

  sock_xfer_cnt #(.CW(CW), .NW(NW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .state_i    (state),
    .unit_buf_i (unit_buf_i),
    .size_i     (xfer_size_i),
    .beat_i     (beat),
    .bytes_i    (core_bytes_i),
    .wb_done_i  (wr_req && mem_ack_i),
    .done_o     (done),
    .reach_o    (reach),
    .count_o    (xfer_count_o)
  );

  assign mem_req_o    = rd_req || wr_req;
  assign mem_we_o     = wr_req;
  assign mem_addr_o   = dscr_ptr_i;
  assign mem_wdata_o  = wr_req ? fill : '0;
  assign core_ready_o = (state == ST_ACTIVE);
  assign evt_req_o    = (state == ST_WAIT);
  assign state_o      = state;

  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o || !en_i || susp_i));
  p_wb_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && !mem_ack_i && en_i) |=> $stable(mem_wdata_o));
endmodule

// File: tb/tb_dma_sock_ctrl.sv
module tb_dma_sock_ctrl;
  localparam int AW = 16, BW = 16, CW = 20, NW = 4;
  localparam int S_DESCR = 0, S_STALL = 1, S_ACT = 2, S_EVT = 3,
                 S_CHK1 = 4, S_SUSP = 5, S_CHK2 = 6, S_WAIT = 7;
  localparam logic [AW-1:0] PTR = 16'h0040;

  logic clk_i = 0, rst_ni = 0;
  logic en_i = 0, susp_i = 0, evt_en_i = 0, unit_buf_i = 0;
  logic [CW-1:0] xfer_size_i = '0;
  logic [AW-1:0] dscr_ptr_i = PTR;
  logic mem_req_o, mem_we_o, mem_ack_i = 0;
  logic [AW-1:0] mem_addr_o;
  logic [BW-1:0] mem_wdata_o, mem_rdata_i = '0;
  logic data_rdy_i = 0, core_valid_i = 0, core_eop_i = 0, core_ready_o;
  logic [NW-1:0] core_bytes_i = '0;
  logic evt_req_o, evt_ack_i = 0;
  logic [2:0] state_o;
  logic [CW-1:0] xfer_count_o;

  int errors = 0, checks = 0;
  int exp_cnt;

  always #2 clk_i = ~clk_i;

  dma_sock_ctrl #(.AW(AW), .BW(BW), .CW(CW), .NW(NW)) dut (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic fetch(input int sz);
    chk("R3 read req", {mem_req_o, mem_we_o}, 2);
    chk("R3 read addr", mem_addr_o, PTR);
    mem_ack_i = 1; mem_rdata_i = BW'(sz);
    tick();
    mem_ack_i = 0;
    chk("R3 to stall", state_o, S_STALL);
    chk("R5 not ready in stall", core_ready_o, 0);
    data_rdy_i = 1;
    tick();
    data_rdy_i = 0;
    chk("R5 to active", state_o, S_ACT);
    chk("R5 ready in active", core_ready_o, 1);
  endtask

  task automatic beat(input int n, input bit eop, input bit valid);
    core_valid_i = valid; core_bytes_i = NW'(n); core_eop_i = eop;
    tick();
    core_valid_i = 0; core_bytes_i = '0; core_eop_i = 0;
  endtask

  task automatic close_out(input int wdata, input bit evt);
    chk("R6 first check", state_o, S_CHK1);
    tick();
    chk("R6 second check", state_o, S_CHK2);
    tick();
    chk("R7 to event", state_o, S_EVT);
    chk("R8 write req", {mem_req_o, mem_we_o}, 3);
    chk("R8 write data", mem_wdata_o, wdata);
    evt_en_i = evt;
    mem_ack_i = 1;
    tick();
    mem_ack_i = 0;
    chk("R8 after write-back", state_o, evt ? S_WAIT : S_DESCR);
    if (evt) begin
      chk("R9 event req", evt_req_o, 1);
      evt_ack_i = 1;
      tick();
      evt_ack_i = 0;
      chk("R9 confirmed", state_o, S_DESCR);
      chk("R9 event req low", evt_req_o, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #5 rst_ni = 1;
    tick();
    chk("R1 reset state", state_o, S_DESCR);
    chk("R1 reset count", xfer_count_o, 0);
    chk("R1 no req", {mem_req_o, evt_req_o}, 0);

    // byte unit, size 20, events on
    xfer_size_i = 20; evt_en_i = 1; en_i = 1;
    #1;
    fetch(8);
    data_rdy_i = 0;
    beat(3, 0, 1);
    chk("R10 bytes counted", xfer_count_o, 3);
    chk("R6 stays active", state_o, S_ACT);
    beat(2, 1, 1);
    chk("R10 eop beat counted", xfer_count_o, 5);
    chk("R6 eop to check", state_o, S_CHK1);
    tick(); tick();
    chk("R2 event code", state_o, S_EVT);
    susp_i = 1;
    chk("R8 wdata", mem_wdata_o, 5);
    tick();
    chk("R4 susp ignored in event", state_o, S_EVT);
    mem_ack_i = 1; tick(); mem_ack_i = 0;
    chk("R8 to waiting", state_o, S_WAIT);
    tick();
    chk("R9 holds without ack", state_o, S_WAIT);
    evt_ack_i = 1; tick(); evt_ack_i = 0;
    chk("R9 back to descr", state_o, S_DESCR);
    chk("R3 no req when suspended", mem_req_o, 0);
    tick();
    chk("R4 suspended", state_o, S_SUSP);
    susp_i = 0; tick();
    chk("R4 release", state_o, S_DESCR);
    chk("R12 count kept", xfer_count_o, 5);
    fetch(8);
    beat(4, 0, 1);
    chk("R6 not yet full", state_o, S_ACT);
    beat(4, 0, 1);
    chk("R10 count 13", xfer_count_o, 13);
    close_out(8, 0);
    fetch(8);
    beat(0, 1, 0);
    tick(); tick();
    chk("R7 empty eop resumes", state_o, S_ACT);
    beat(7, 1, 1);
    chk("R10 count 20", xfer_count_o, 20);
    close_out(7, 1);
    chk("R11 done blocks fetch", mem_req_o, 0);
    tick();
    chk("R11 stays descr", state_o, S_DESCR);
    en_i = 0; tick();
    chk("R12 cleared", xfer_count_o, 0);

    // buffer unit, size 3, events off
    unit_buf_i = 1; xfer_size_i = 3; en_i = 1; #1;
    for (int i = 1; i <= 3; i++) begin
      fetch(4);
      beat(2, 1, 1);
      chk("R10 beats not counted in buffer unit", xfer_count_o, i - 1);
      close_out(2, 0);
      chk("R10 buffer counted", xfer_count_o, i);
    end
    chk("R11 done in buffer unit", mem_req_o, 0);
    xfer_size_i = 4; #1;
    fetch(4);
    beat(0, 1, 0);
    tick(); tick();
    chk("R11 reach closes empty buffer", state_o, S_EVT);
    mem_ack_i = 1; tick(); mem_ack_i = 0;
    chk("R10 count 4", xfer_count_o, 4);
    chk("R11 done again", mem_req_o, 0);
    xfer_size_i = 0; #1;
    chk("R11 unlimited", mem_req_o, 1);
    mem_ack_i = 1; mem_rdata_i = 4; tick(); mem_ack_i = 0;
    susp_i = 1; tick();
    chk("R4 susp ignored in stall", state_o, S_STALL);
    data_rdy_i = 1; tick(); data_rdy_i = 0;
    chk("R4 active despite susp", state_o, S_ACT);
    susp_i = 0;
    en_i = 0; tick();
    chk("R12 disable from active", state_o, S_DESCR);
    chk("R12 count cleared", xfer_count_o, 0);

    // sweep of beat sizes, byte unit, unlimited
    unit_buf_i = 0; en_i = 1; #1;
    exp_cnt = 0;
    for (int b = 1; b <= 7; b++) begin
      fetch(2 * b);
      beat(b, 0, 1);
      exp_cnt += b;
      chk("R6 half full stays", state_o, S_ACT);
      beat(b, 0, 1);
      exp_cnt += b;
      chk("R10 sweep count", xfer_count_o, exp_cnt);
      close_out(2 * b, b[0]);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule